// File: doc/BRIEF.md
# Calendar time-of-year counter

A calendar clock for a slow 32.768 kHz oscillator domain, reached from a fast bus clock through a small register window. A prescaler divides the oscillator by a programmable trim value plus one, which gives a 1 Hz tick at the reset trim of 32767. Each tick moves a packed calendar word forward: seconds, minutes, hours, day of month and month. Rollovers follow the true month lengths, and February gets 29 days in leap years. The absolute year sits in its own 32-bit register and counts up when December rolls into January.

Software writes a new time word, year or trim value on the bus clock. The value waits in a holding register while a toggle handshake carries it into the slow domain. A busy flag in the control word stays set until the slow side has taken the value. Any write that arrives while the matching busy flag is set is dropped. In the other direction, the slow domain copies its time and year into bus-side mirror registers every time they change, and the two are copied together. A read therefore never returns a seconds rollover with only half of it applied. The control word also shows whether the oscillator is toggling, and it holds an enable bit that freezes counting when cleared.

Top module: `cal_clock`

## Requirements
- R1: Offset 0x0C reads the time word with month in bits [31:26] (1..12), day in [25:21], hours in [20:16], minutes in [15:10] and seconds in [9:4]. Bits [3:0] read 0, and any value written to those bits through offset 0x04 is dropped. Offset 0x10 reads the full 32-bit year. After reset the time reads month 1, day 1, 00:00:00 and the year reads 2000.
- R2: Offset 0x00 reads back the trim value. Trim resets to 32767. Once a trim value T has been taken into the slow domain, the calendar advances once every T+1 slow-clock cycles.
- R3: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R4: A day past the last day of its month becomes day 1 of the next month. April, June, September and November have 30 days, the other months have 31, and February is covered by R5. December rolls into January and the year goes up by one.
- R5: February has 29 days when the year is divisible by 4, except for 1900, and 28 days otherwise.
- R6: A write to 0x04 (time) or 0x08 (year) sets control bit 0 from the next bus cycle. The bit clears within 4 slow-clock cycles. By then the written value can be read back, and the prescaler restarts from zero after a time write.
- R7: A write to 0x00 (trim) sets control bit 4 from the next bus cycle, and the bit clears within 4 slow-clock cycles.
- R8: A time or year write made while control bit 0 is set is ignored. A trim write made while control bit 4 is set is ignored.
- R9: Control bit 5 reads 1 while the slow clock toggles. It reads 0 once the slow clock has been still for more than OSC_TIMEOUT bus cycles.
- R10: Control bit 8 is the counter enable. It resets to 1 and is written through offset 0x20. While it is 0 the calendar holds its value, and setting it back to 1 resumes counting.
- R11: When a rollover changes both the time word and the year, a year read in the bus cycle right after the new time word becomes visible already returns the new year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| slowClk | input | 1 | 32.768 kHz oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWrEn | input | 1 | Write strobe, sampled on busClk |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
The bench sets dates just before the awkward boundaries and checks the single step that follows against its own calendar model. It covers a minute carry, a day carry, a 30-day and a 31-day month end, February in a common year, in a leap year and in 1900, and the end of 2099. A design with a wrong month table or leap rule would land on day 29, 30 or 31 where day 1 of the next month is due. The bench reads the year immediately after the new-year rollover, so a design that updates the year mirror separately from the time mirror returns the old year there. It also times the busy flags in slow-clock edges, writes again while busy to catch a design that accepts late writes, measures the tick period for two trim values, and stops the slow clock to check that the oscillator bit drops.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [5:0] OFS_TRIM  = 6'h00;
  localparam logic [5:0] OFS_TWR   = 6'h04;
  localparam logic [5:0] OFS_YWR   = 6'h08;
  localparam logic [5:0] OFS_TRD   = 6'h0C;
  localparam logic [5:0] OFS_YRD   = 6'h10;
  localparam logic [5:0] OFS_CTRL  = 6'h20;

  localparam int CTL_CALBUSY  = 0;
  localparam int CTL_TRIMBUSY = 4;
  localparam int CTL_OSCOK    = 5;
  localparam int CTL_EN       = 8;

  // Field order matches bits [31:4] of the time word.
  typedef struct packed {
    logic [5:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } calWord_t;

  localparam calWord_t CAL_RESET = '{mon: 6'd1, day: 5'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

  // Load strobes from the handshake control into the slow datapath.
  typedef struct packed {
    logic timeLoad;
    logic yearLoad;
    logic trimLoad;
  } slowStrb_t;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int TRIM_W     = 16,
  parameter int TRIM_RESET = 32767,
  parameter int YEAR_RESET = 2000
) (
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              en,
  input  slowStrb_t         strb,
  input  calWord_t          holdTime,
  input  logic [31:0]       holdYear,
  input  logic [TRIM_W-1:0] holdTrim,
  output calWord_t          curTime,
  output logic [31:0]       curYear,
  output logic              chgTog,
  output logic              beat
);
  logic [TRIM_W-1:0] trimR, preCnt;
  logic              tick, carryYear;
  calWord_t          nxt;

  function automatic logic [4:0] monthLen(input logic [5:0] mon, input logic [31:0] yr);
    logic leap;
    leap = (yr[1:0] == 2'b00) && (yr != 32'd1900);
    case (mon)
      6'd2:                    monthLen = leap ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11: monthLen = 5'd30;
      default:                 monthLen = 5'd31;
    endcase
  endfunction

  assign tick = en && (preCnt >= trimR);

  always_comb begin
    nxt       = curTime;
    carryYear = 1'b0;
    if (curTime.sec >= 6'd59) begin
      nxt.sec = '0;
      if (curTime.min >= 6'd59) begin
        nxt.min = '0;
        if (curTime.hour >= 5'd23) begin
          nxt.hour = '0;
          if (curTime.day >= monthLen(curTime.mon, curYear)) begin
            nxt.day = 5'd1;
            if (curTime.mon >= 6'd12) begin
              nxt.mon   = 6'd1;
              carryYear = 1'b1;
            end else nxt.mon = curTime.mon + 6'd1;
          end else nxt.day = curTime.day + 5'd1;
        end else nxt.hour = curTime.hour + 5'd1;
      end else nxt.min = curTime.min + 6'd1;
    end else nxt.sec = curTime.sec + 6'd1;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      trimR   <= TRIM_W'(TRIM_RESET);
      preCnt  <= '0;
      curTime <= CAL_RESET;
      curYear <= 32'(YEAR_RESET);
      chgTog  <= 1'b0;
      beat    <= 1'b0;
    end else begin
      beat <= ~beat;
      if (strb.trimLoad) trimR <= holdTrim;
      if (strb.timeLoad) begin
        curTime <= holdTime;
        preCnt  <= '0;
      end else if (en) begin
        preCnt <= tick ? '0 : preCnt + 1'b1;
        if (tick) curTime <= nxt;
      end
      if (strb.yearLoad) curYear <= holdYear;
      else if (tick && carryYear && !strb.timeLoad) curYear <= curYear + 32'd1;
      if (strb.timeLoad || strb.yearLoad || tick) chgTog <= ~chgTog;
    end
  end

  AST_PRESCALE_WRAP: assert property (@(posedge slowClk) disable iff (!rstN)
    (en && !strb.timeLoad && preCnt > trimR) |=> (preCnt == '0)); // R2
  AST_SEC_RANGE: assert property (@(posedge slowClk) disable iff (!rstN)
    (tick && !strb.timeLoad && curTime.sec <= 6'd59) |=> (curTime.sec <= 6'd59)); // R3
  AST_MON_RANGE: assert property (@(posedge slowClk) disable iff (!rstN)
    (tick && !strb.timeLoad && curTime.mon >= 6'd1 && curTime.mon <= 6'd12)
      |=> (curTime.mon >= 6'd1 && curTime.mon <= 6'd12)); // R4
  AST_YEAR_STEP: assert property (@(posedge slowClk) disable iff (!rstN)
    (!strb.yearLoad) |=> (curYear == $past(curYear) || curYear == $past(curYear) + 32'd1)); // R4
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int TRIM_W      = 16,
  parameter int TRIM_RESET  = 32767,
  parameter int YEAR_RESET  = 2000,
  parameter int OSC_TIMEOUT = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output calWord_t          holdTime,
  output logic [31:0]       holdYear,
  output logic [TRIM_W-1:0] holdTrim,
  output slowStrb_t         strb,
  output logic              enSlow,
  input  calWord_t          curTime,
  input  logic [31:0]       curYear,
  input  logic              chgTog,
  input  logic              beat
);
  localparam int ACK_STAGES = SYNC_STAGES + 1;
  localparam int OSC_W      = $clog2(OSC_TIMEOUT + 1);

  logic calReq, calIsYear, trimReq, enReg;
  logic calAckB, trimAckB, chgB, chgBq, beatB, beatBq;
  logic calReqS, calReqSq, trimReqS, trimReqSq;
  logic calBusy, trimBusy, oscOk;
  logic wrTime, wrYear, wrTrim, wrCtrl;
  logic [OSC_W-1:0] oscCnt;
  calWord_t    mirTime;
  logic [31:0] mirYear;

  // bus -> slow
  cal_sync #(.STAGES(SYNC_STAGES)) syncCalReq  (.clk(slowClk), .rstN(rstN), .d(calReq),  .q(calReqS));
  cal_sync #(.STAGES(SYNC_STAGES)) syncTrimReq (.clk(slowClk), .rstN(rstN), .d(trimReq), .q(trimReqS));
  cal_sync #(.STAGES(SYNC_STAGES)) syncEn      (.clk(slowClk), .rstN(rstN), .d(enReg),   .q(enSlow));
  // slow -> bus
  cal_sync #(.STAGES(ACK_STAGES))  syncCalAck  (.clk(busClk), .rstN(rstN), .d(calReqSq),  .q(calAckB));
  cal_sync #(.STAGES(ACK_STAGES))  syncTrimAck (.clk(busClk), .rstN(rstN), .d(trimReqSq), .q(trimAckB));
  cal_sync #(.STAGES(SYNC_STAGES)) syncChg     (.clk(busClk), .rstN(rstN), .d(chgTog),    .q(chgB));
  cal_sync #(.STAGES(SYNC_STAGES)) syncBeat    (.clk(busClk), .rstN(rstN), .d(beat),      .q(beatB));

  assign calBusy  = calReq ^ calAckB;
  assign trimBusy = trimReq ^ trimAckB;
  assign oscOk    = (oscCnt != OSC_W'(OSC_TIMEOUT));

  assign wrTime = busWrEn && (busAddr == ADDR_W'(OFS_TWR)) && !calBusy;
  assign wrYear = busWrEn && (busAddr == ADDR_W'(OFS_YWR)) && !calBusy;
  assign wrTrim = busWrEn && (busAddr == ADDR_W'(OFS_TRIM)) && !trimBusy;
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      holdTime  <= CAL_RESET;
      holdYear  <= 32'(YEAR_RESET);
      holdTrim  <= TRIM_W'(TRIM_RESET);
      calReq    <= 1'b0;
      calIsYear <= 1'b0;
      trimReq   <= 1'b0;
      enReg     <= 1'b1;
      chgBq     <= 1'b0;
      beatBq    <= 1'b0;
      oscCnt    <= OSC_W'(OSC_TIMEOUT);
      mirTime   <= CAL_RESET;
      mirYear   <= 32'(YEAR_RESET);
    end else begin
      if (wrTime) begin
        holdTime  <= busWdata[31:4];
        calIsYear <= 1'b0;
      end
      if (wrYear) begin
        holdYear  <= busWdata;
        calIsYear <= 1'b1;
      end
      if (wrTime || wrYear) calReq <= ~calReq;
      if (wrTrim) begin
        holdTrim <= busWdata[TRIM_W-1:0];
        trimReq  <= ~trimReq;
      end
      if (wrCtrl) enReg <= busWdata[CTL_EN];
      chgBq <= chgB;
      if (chgB ^ chgBq) begin
        mirTime <= curTime;
        mirYear <= curYear;
      end
      beatBq <= beatB;
      if (beatB ^ beatBq) oscCnt <= '0;
      else if (oscOk)     oscCnt <= oscCnt + 1'b1;
    end
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      calReqSq  <= 1'b0;
      trimReqSq <= 1'b0;
    end else begin
      calReqSq  <= calReqS;
      trimReqSq <= trimReqS;
    end
  end

  always_comb begin
    strb.timeLoad = (calReqS ^ calReqSq) & ~calIsYear;
    strb.yearLoad = (calReqS ^ calReqSq) & calIsYear;
    strb.trimLoad = trimReqS ^ trimReqSq;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_TRIM): busRdata = 32'(holdTrim);
      ADDR_W'(OFS_TRD):  busRdata = {mirTime, 4'b0000};
      ADDR_W'(OFS_YRD):  busRdata = mirYear;
      ADDR_W'(OFS_CTRL): begin
        busRdata[CTL_CALBUSY]  = calBusy;
        busRdata[CTL_TRIMBUSY] = trimBusy;
        busRdata[CTL_OSCOK]    = oscOk;
        busRdata[CTL_EN]       = enReg;
      end
      default: busRdata = '0;
    endcase
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && (busAddr == ADDR_W'(OFS_TWR) || busAddr == ADDR_W'(OFS_YWR)) && !calBusy) |=> calBusy); // R6
  AST_TRIM_BUSY_ON_WRITE: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_TRIM) && !trimBusy) |=> trimBusy); // R7
  AST_TIME_IGNORED: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && calBusy) |=> ($stable(holdTime) && $stable(holdYear))); // R8
  AST_TRIM_IGNORED: assert property (@(posedge busClk) disable iff (!rstN)
    (busWrEn && trimBusy) |=> $stable(holdTrim)); // R8
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int TRIM_W      = 16,
  parameter int TRIM_RESET  = 32767,
  parameter int YEAR_RESET  = 2000,
  parameter int OSC_TIMEOUT = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  calWord_t          holdTime, curTime;
  logic [31:0]       holdYear, curYear;
  logic [TRIM_W-1:0] holdTrim;
  slowStrb_t         strb;
  logic              enSlow, chgTog, beat;

  cal_ctrl #(
    .ADDR_W(ADDR_W), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET),
    .YEAR_RESET(YEAR_RESET), .OSC_TIMEOUT(OSC_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .holdTime(holdTime), .holdYear(holdYear), .holdTrim(holdTrim),
    .strb(strb), .enSlow(enSlow),
    .curTime(curTime), .curYear(curYear), .chgTog(chgTog), .beat(beat)
  );

  cal_datapath #(
    .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET), .YEAR_RESET(YEAR_RESET)
  ) dp_i (
    .slowClk(slowClk), .rstN(rstN), .en(enSlow), .strb(strb),
    .holdTime(holdTime), .holdYear(holdYear), .holdTrim(holdTrim),
    .curTime(curTime), .curYear(curYear), .chgTog(chgTog), .beat(beat)
  );
endmodule

// File: tb/cal_clock_tb_top.sv
module cal_clock_tb_top;
  logic        busClk = 1'b0, slowClk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  wire  [31:0] busRdata;
  bit          slowRun = 1'b1;
  int          slowCount = 0, cyc = 0, errors = 0, checks = 0;
  // reference calendar state
  int my, mmo, md, mh, mmi, ms;
  logic [31:0] curT, curY;
  int lastAt;

  cal_clock dut_i (.busClk(busClk), .slowClk(slowClk), .rstN(rstN), .busWrEn(busWrEn),
                   .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata));

  always #2 busClk = ~busClk;
  always begin #16; if (slowRun) slowClk = ~slowClk; end
  always @(posedge slowClk) slowCount++;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge busClk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(int mo, int d, int h, int mi, int s);
    return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) | (32'(s) << 4);
  endfunction

  task automatic modelStep();
    int len;
    bit leap;
    leap = (my % 4 == 0) && (my != 1900);
    if (mmo == 2) len = leap ? 29 : 28;
    else if (mmo == 4 || mmo == 6 || mmo == 9 || mmo == 11) len = 30;
    else len = 31;
    ms++;
    if (ms == 60) begin ms = 0; mmi++; end
    if (mmi == 60) begin mmi = 0; mh++; end
    if (mh == 24) begin mh = 0; md++; end
    if (md > len) begin md = 1; mmo++; end
    if (mmo == 13) begin mmo = 1; my++; end
  endtask

  task automatic busWrite(logic [5:0] a, logic [31:0] d);
    @(negedge busClk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge busClk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [5:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      busRead(6'h20, v);
      if ((v & 32'h11) == 0) break;
    end
  endtask

  task automatic waitChange(string tag);
    logic [31:0] t, y;
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      busRead(6'h0C, t);
      if (t != curT) begin
        busRead(6'h10, y);
        lastAt = slowCount;
        seen = 1'b1;
        break;
      end
    end
    modelStep();
    if (!seen) begin t = curT; y = curY; end
    checkEq({tag, " next time"}, t, pk(mmo, md, mh, mmi, ms));
    checkEq("R11 year with time", y, 32'(my));
    curT = t; curY = y;
  endtask

  task automatic runStep(int y, int mo, int d, int h, int mi, int s, logic [3:0] low, string tag);
    logic [31:0] v;
    busWrite(6'h20, 32'h0);
    repeat (48) @(negedge busClk);
    busWrite(6'h08, 32'(y)); waitIdle();
    busWrite(6'h04, pk(mo, d, h, mi, s) | 32'(low)); waitIdle();
    busRead(6'h0C, v); checkEq("R1 time readback", v, pk(mo, d, h, mi, s));
    curT = v;
    busRead(6'h10, v); checkEq("R1 year readback", v, 32'(y));
    curY = v;
    my = y; mmo = mo; md = d; mh = h; mmi = mi; ms = s;
    busWrite(6'h20, 32'h100);
    waitChange(tag);
  endtask

  initial begin
    logic [31:0] v, t;
    int s0, a1;
    repeat (10) @(negedge busClk);
    rstN = 1'b1;
    repeat (40) @(negedge busClk);

    // reset state
    busRead(6'h0C, v); checkEq("R1 reset time", v, pk(1, 1, 0, 0, 0));
    busRead(6'h10, v); checkEq("R1 reset year", v, 32'd2000);
    busRead(6'h00, v); checkEq("R2 reset trim", v, 32'd32767);
    busRead(6'h20, v); checkEq("R10 R9 reset control", v, 32'h120);

    // trim handshake timing and ignored second write
    s0 = slowCount;
    busWrite(6'h00, 32'd3);
    busRead(6'h20, v); checkEq("R7 trim busy set", 32'(v[4]), 32'd1);
    busWrite(6'h00, 32'd9);
    waitIdle();
    checkEq("R7 trim busy within 4 slow cycles", 32'(slowCount - s0 <= 4), 32'd1);
    busRead(6'h00, v); checkEq("R8 trim write while busy ignored", v, 32'd3);

    // time/year handshake with counting halted
    busWrite(6'h20, 32'h0);
    repeat (48) @(negedge busClk);
    busRead(6'h20, v); checkEq("R10 enable reads 0", 32'(v[8]), 32'd0);
    waitIdle();
    s0 = slowCount;
    busWrite(6'h08, 32'd1999);
    busRead(6'h20, v); checkEq("R6 busy set", 32'(v[0]), 32'd1);
    waitIdle();
    checkEq("R6 busy within 4 slow cycles", 32'(slowCount - s0 <= 4), 32'd1);
    busWrite(6'h04, pk(3, 7, 8, 9, 10));
    busWrite(6'h08, 32'd2050);
    waitIdle();
    busRead(6'h10, v); checkEq("R8 year write while busy ignored", v, 32'd1999);
    busRead(6'h0C, t); checkEq("R6 time loaded", t, pk(3, 7, 8, 9, 10));
    repeat (300) @(negedge busClk);
    busRead(6'h0C, v); checkEq("R10 halted time stable", v, t);

    // calendar steps
    runStep(2023, 6, 15, 10, 20, 30, 4'hF, "R3 seconds");
    a1 = lastAt;
    waitChange("R3 seconds");
    checkEq("R2 period trim 3", 32'(lastAt - a1), 32'd4);
    runStep(2023, 6, 15, 10, 59, 59, 4'h0, "R3 minute hour carry");
    runStep(2023, 6, 15, 23, 59, 59, 4'h0, "R3 day carry");
    runStep(2023, 4, 30, 23, 59, 59, 4'h0, "R4 30-day month");
    runStep(2023, 1, 31, 23, 59, 59, 4'h0, "R4 31-day month");
    runStep(2023, 2, 28, 23, 59, 59, 4'h0, "R5 common February");
    runStep(2024, 2, 28, 23, 59, 59, 4'h0, "R5 leap February 28");
    runStep(2024, 2, 29, 23, 59, 59, 4'h0, "R5 leap February 29");
    runStep(1900, 2, 28, 23, 59, 59, 4'h0, "R5 year 1900");
    runStep(2099, 12, 31, 23, 59, 59, 4'h0, "R4 new year");

    // second trim value
    busWrite(6'h00, 32'd6); waitIdle();
    runStep(2030, 8, 1, 5, 5, 5, 4'h0, "R2 trim 6");
    a1 = lastAt;
    waitChange("R2 trim 6");
    checkEq("R2 period trim 6", 32'(lastAt - a1), 32'd7);

    // halt while running, then resume
    busWrite(6'h20, 32'h0);
    repeat (60) @(negedge busClk);
    busRead(6'h0C, t);
    curT = t;
    repeat (400) @(negedge busClk);
    busRead(6'h0C, v); checkEq("R10 halted while running", v, t);
    my = 32'(curY); mmo = int'(t[31:26]); md = int'(t[25:21]);
    mh = int'(t[20:16]); mmi = int'(t[15:10]); ms = int'(t[9:4]);
    busWrite(6'h20, 32'h100);
    waitChange("R10 resume");

    // oscillator watch
    slowRun = 1'b0;
    repeat (120) @(negedge busClk);
    busRead(6'h20, v); checkEq("R9 oscillator stopped", 32'(v[5]), 32'd0);
    slowRun = 1'b1;
    repeat (60) @(negedge busClk);
    busRead(6'h20, v); checkEq("R9 oscillator running", 32'(v[5]), 32'd1);

    summary();
    $finish;
  end
endmodule